// File: doc/BRIEF.md
# Multi-Channel Edge-Programmed PWM Generator

This block drives sixteen pulse-width outputs from one shared time base. A prescaler divides the input clock into steps, and a step counter runs from zero up to a programmed limit and then wraps. The wrap marks the start of a period. Each channel has no duty value. It holds two absolute step positions instead: one where the output goes high and one where it goes low. Software selects duty and polarity by placing these two edges.

All settings are written and read over a plain byte-wide register bus. Each channel can be placed in staged mode through a per-channel mask. In staged mode, writes to the channel's edge registers land in a hidden copy, and that copy moves into the live registers only when the next period starts, so the waveform never glitches mid-period. While any channel is staged, the shared prescale and period limit are staged the same way. Reads always return the live value, and no flag shows that an update is still waiting.

Top module: `pwm_edge_gen`

## Requirements
- R1: After synchronous reset every output is low and every register reads back as zero.
- R2: The period is (prescale+1)*(limit+1) clocks, with prescale at 0x00 and limit at 0x04. A channel output is high from one clock after the first clock of its rise step until one clock after the first clock of its fall step. The rise position of channel n is at 0x10+8n and the fall position at 0x14+8n.
- R3: An edge position above the period limit never matches. Rise above the limit with fall at 0 keeps the output low, and rise at 0 with fall above the limit keeps it high.
- R4: When the rise and fall positions are equal, the output toggles once per period, which gives a 50% waveform at twice the period.
- R5: Channel enables sit in a byte at 0x08 (channels 0 to 7, bit n = channel n) and a byte at 0x0C (channels 8 to 15, bit n-8). A disabled channel drives low.
- R6: For a channel whose staging bit is clear, an edge write takes effect at once. A read presents the byte for the given address on bus_rdata one clock after the address is applied.
- R7: The staging mask sits at 0xE4 (channels 0 to 7) and 0xE8 (channels 8 to 15). For a staged channel, an edge write is held back: reads return the old live value until the next period start, and the new value after it.
- R8: A staged edge write that lands in the same clock as a period start stays pending until the following period start. A write one clock earlier is applied at that period start.
- R9: While any staging bit is set, writes to prescale and the period limit are held until the next period start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the previous clock's address |
| pwm_out | output | 16 | Channel outputs, registered |

## Verification
The period-start transfer from staged to live registers can fall in the same clock as a bus write to a staged edge register. The bench provokes this by locking onto the rising edge of a reference channel programmed with a rise at step 0. It then counts clocks so that one write lands exactly on the period-start clock and another lands one clock before it. The result is judged by reading the staged register back just after that boundary and again after the next one. The late write must still show the old value and then appear one period later. The early write must appear at once.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int AW = 8;
  typedef logic [AW-1:0] addr_t;

  localparam addr_t A_PRESCALE  = 8'h00;
  localparam addr_t A_PERIOD    = 8'h04;
  localparam addr_t A_EN_BASE   = 8'h08;
  localparam addr_t A_EDGE_BASE = 8'h10;
  localparam addr_t A_SYNC_BASE = 8'hE4;
  localparam int    CH_STRIDE   = 8;
  localparam int    FALL_OFS    = 4;
  localparam int    BANK_STRIDE = 4;

  function automatic addr_t rise_addr(input int ch);
    return A_EDGE_BASE + addr_t'(ch * CH_STRIDE);
  endfunction

  function automatic addr_t fall_addr(input int ch);
    return rise_addr(ch) + addr_t'(FALL_OFS);
  endfunction

  function automatic addr_t en_addr(input int bank);
    return A_EN_BASE + addr_t'(bank * BANK_STRIDE);
  endfunction

  function automatic addr_t sync_addr(input int bank);
    return A_SYNC_BASE + addr_t'(bank * BANK_STRIDE);
  endfunction
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] prescale,
  input  logic [DW-1:0] period_lim,
  output logic [DW-1:0] step,
  output logic          step_first,
  output logic          period_start
);
  logic [DW-1:0] pre_cnt;
  logic          tick;

  // >= keeps the counters bounded when a limit shrinks mid-period
  assign tick         = (pre_cnt >= prescale);
  assign step_first   = (pre_cnt == '0);
  assign period_start = tick && (step >= period_lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
      step    <= '0;
    end else if (tick) begin
      pre_cnt <= '0;
      step    <= period_start ? '0 : step + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_first,
  input  logic [DW-1:0] step,
  input  logic [DW-1:0] rise_at,
  input  logic [DW-1:0] fall_at,
  input  logic          enable,
  output logic          pwm_q
);
  logic lvl_q, lvl_d, hit_r, hit_f;

  always_comb begin
    hit_r = step_first && (step == rise_at);
    hit_f = step_first && (step == fall_at);
    lvl_d = lvl_q;
    if (hit_r && hit_f)  lvl_d = ~lvl_q;
    else if (hit_r)      lvl_d = 1'b1;
    else if (hit_f)      lvl_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
      pwm_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      pwm_q <= enable & lvl_d;
    end
  end
endmodule

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DW     = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_wr,
  input  addr_t                     bus_addr,
  input  logic [DW-1:0]             bus_wdata,
  input  logic                      period_start,
  output logic [DW-1:0]             prescale_act,
  output logic [DW-1:0]             period_act,
  output logic [NUM_CH-1:0]         ch_en,
  output logic [NUM_CH-1:0]         sync_en,
  output logic [NUM_CH-1:0][DW-1:0] rise_act,
  output logic [NUM_CH-1:0][DW-1:0] fall_act,
  output logic [DW-1:0]             bus_rdata
);
  localparam int NBANK = NUM_CH / DW;

  logic [DW-1:0]             prescale_sh, period_sh;
  logic [NUM_CH-1:0][DW-1:0] rise_sh, fall_sh;
  logic                      any_sync;
  logic [DW-1:0]             rd_mux;

  assign any_sync = |sync_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      prescale_sh  <= '0;
      period_sh    <= '0;
      prescale_act <= '0;
      period_act   <= '0;
      rise_sh      <= '0;
      fall_sh      <= '0;
      rise_act     <= '0;
      fall_act     <= '0;
      ch_en        <= '0;
      sync_en      <= '0;
      bus_rdata    <= '0;
    end else begin
      // boundary transfer first; a same-cycle write below overrides it
      if (period_start) begin
        prescale_act <= prescale_sh;
        period_act   <= period_sh;
        rise_act     <= rise_sh;
        fall_act     <= fall_sh;
      end
      if (bus_wr) begin
        if (bus_addr == A_PRESCALE) begin
          prescale_sh <= bus_wdata;
          if (!any_sync) prescale_act <= bus_wdata;
        end
        if (bus_addr == A_PERIOD) begin
          period_sh <= bus_wdata;
          if (!any_sync) period_act <= bus_wdata;
        end
        for (int b = 0; b < NBANK; b++) begin
          if (bus_addr == en_addr(b))   ch_en[b*DW +: DW]   <= bus_wdata;
          if (bus_addr == sync_addr(b)) sync_en[b*DW +: DW] <= bus_wdata;
        end
        for (int c = 0; c < NUM_CH; c++) begin
          if (bus_addr == rise_addr(c)) begin
            rise_sh[c] <= bus_wdata;
            if (!sync_en[c]) rise_act[c] <= bus_wdata;
          end
          if (bus_addr == fall_addr(c)) begin
            fall_sh[c] <= bus_wdata;
            if (!sync_en[c]) fall_act[c] <= bus_wdata;
          end
        end
      end
      bus_rdata <= rd_mux;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_PRESCALE) rd_mux = prescale_act;
    if (bus_addr == A_PERIOD)   rd_mux = period_act;
    for (int b = 0; b < NBANK; b++) begin
      if (bus_addr == en_addr(b))   rd_mux = ch_en[b*DW +: DW];
      if (bus_addr == sync_addr(b)) rd_mux = sync_en[b*DW +: DW];
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (bus_addr == rise_addr(c)) rd_mux = rise_act[c];
      if (bus_addr == fall_addr(c)) rd_mux = fall_act[c];
    end
  end
endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  logic [DW-1:0]             prescale_act, period_act;
  logic [NUM_CH-1:0]         ch_en, sync_en;
  logic [NUM_CH-1:0][DW-1:0] rise_act, fall_act;
  logic [DW-1:0]             step;
  logic                      step_first, period_start;

  pwm_regfile #(.NUM_CH(NUM_CH), .DW(DW)) regs_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .period_start(period_start),
    .prescale_act(prescale_act), .period_act(period_act),
    .ch_en(ch_en), .sync_en(sync_en), .rise_act(rise_act),
    .fall_act(fall_act), .bus_rdata(bus_rdata)
  );

  pwm_timebase #(.DW(DW)) tb_i (
    .clk(clk), .rst(rst), .prescale(prescale_act), .period_lim(period_act),
    .step(step), .step_first(step_first), .period_start(period_start)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_channel #(.DW(DW)) ch_i (
      .clk(clk), .rst(rst), .step_first(step_first), .step(step),
      .rise_at(rise_act[c]), .fall_at(fall_act[c]), .enable(ch_en[c]),
      .pwm_q(pwm_out[c])
    );
  end
endmodule

// File: rtl/pwm_edge_gen_chk.sv
module pwm_edge_gen_chk
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DW     = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      bus_wr,
  input logic [AW-1:0]             bus_addr,
  input logic [DW-1:0]             bus_wdata,
  input logic [NUM_CH-1:0]         pwm_out,
  input logic [NUM_CH-1:0]         ch_en,
  input logic [NUM_CH-1:0]         sync_en,
  input logic                      period_start,
  input logic                      step_first,
  input logic [NUM_CH-1:0][DW-1:0] rise_act,
  input logic [DW-1:0]             period_act
);
  logic rst_seen;
  always_ff @(posedge clk) if (rst) rst_seen <= 1'b1;

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    (rst_seen && $past(rst)) |-> (pwm_out == '0));

  // R2
  quiet_between_steps_chk: assert property (@(posedge clk) disable iff (rst)
    (!step_first && !$past(bus_wr)) |=> $stable(pwm_out));

  // R9
  period_held_chk: assert property (@(posedge clk) disable iff (rst)
    ((|sync_en) && !period_start) |=> $stable(period_act));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R5
    disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(ch_en[c]) |-> !pwm_out[c]);

    // R7
    staged_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (sync_en[c] && !period_start) |=> $stable(rise_act[c]));

    // R6
    direct_write_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && !sync_en[c] && bus_addr == rise_addr(c))
        |=> (rise_act[c] == $past(bus_wdata)));
  end
endmodule

bind pwm_edge_gen pwm_edge_gen_chk #(.NUM_CH(NUM_CH), .DW(DW)) chk_i (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pwm_out(pwm_out), .ch_en(ch_en),
  .sync_en(sync_en), .period_start(period_start), .step_first(step_first),
  .rise_act(rise_act), .period_act(period_act)
);

// File: tb/pwm_edge_gen_tb_top.sv
module pwm_edge_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           bus_wr = 1'b0;
  logic [7:0]     bus_addr = '0;
  logic [7:0]     bus_wdata = '0;
  logic [7:0]     bus_rdata;
  logic [NCH-1:0] pwm_out;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_edge_gen #(.NUM_CH(NCH), .DW(8)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  // {channel, prescale, limit, rise, fall, expected highs over 2 periods, expected rises}
  localparam logic [55:0] VEC [0:7] = '{
    {8'd0,  8'd0, 8'd9, 8'd2, 8'd5, 8'd6,  8'd2},
    {8'd5,  8'd1, 8'd7, 8'd1, 8'd6, 8'd20, 8'd2},
    {8'd9,  8'd2, 8'd4, 8'd4, 8'd1, 8'd12, 8'd2},
    {8'd15, 8'd0, 8'd5, 8'd6, 8'd0, 8'd0,  8'd0},
    {8'd12, 8'd0, 8'd5, 8'd0, 8'd6, 8'd12, 8'd0},
    {8'd7,  8'd1, 8'd3, 8'd2, 8'd2, 8'd8,  8'd1},
    {8'd2,  8'd3, 8'd2, 8'd0, 8'd2, 8'd16, 8'd2},
    {8'd10, 8'd0, 8'd0, 8'd0, 8'd0, 8'd1,  8'd1}
  };

  function automatic logic [7:0] ra(input int ch); return 8'(16 + 8*ch); endfunction
  function automatic logic [7:0] fa(input int ch); return 8'(20 + 8*ch); endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_rise(input int ch);
    logic prev;
    prev = pwm_out[ch];
    forever begin
      @(negedge clk);
      if (pwm_out[ch] && !prev) break;
      prev = pwm_out[ch];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 outputs", pwm_out, 0);
    rd(8'h00, d); chk("R1 prescale", d, 0);
    rd(8'h04, d); chk("R1 limit", d, 0);
    rd(8'h0C, d); chk("R1 enable hi", d, 0);
    rd(ra(3), d); chk("R1 rise ch3", d, 0);

    // table walk: R2, R3, R4, R5
    for (int i = 0; i < 8; i++) begin
      int ch, ps, pe, rs, fl, ehi, er, per, hi, rises;
      logic prev, cur;
      string tag;
      ch = int'(VEC[i][55:48]); ps = int'(VEC[i][47:40]); pe = int'(VEC[i][39:32]);
      rs = int'(VEC[i][31:24]); fl = int'(VEC[i][23:16]);
      ehi = int'(VEC[i][15:8]); er = int'(VEC[i][7:0]);
      if (rs > pe || fl > pe) tag = "R3";
      else if (rs == fl)      tag = "R4";
      else                    tag = "R2";
      wr(8'h08, 8'h00); wr(8'h0C, 8'h00);
      wr(8'h00, 8'(ps)); wr(8'h04, 8'(pe));
      wr(ra(ch), 8'(rs)); wr(fa(ch), 8'(fl));
      wr(ch < 8 ? 8'h08 : 8'h0C, 8'(1 << (ch % 8)));
      per = (ps + 1) * (pe + 1);
      repeat (4 * per + 4) @(negedge clk);
      hi = 0; rises = 0; prev = pwm_out[ch];
      for (int k = 0; k < 2 * per; k++) begin
        @(negedge clk);
        cur = pwm_out[ch];
        if (cur) hi++;
        if (cur && !prev) rises++;
        prev = cur;
      end
      chk({tag, " high clocks"}, hi, ehi);
      chk({tag, " rising edges"}, rises, er);
      chk("R5 other channels low", pwm_out & ~(NCH'(1) << ch), 0);
    end

    // R5 bank mapping
    wr(8'h08, 8'h00); wr(8'h0C, 8'h00);
    wr(8'h00, 8'd0); wr(8'h04, 8'd5);
    wr(ra(4), 8'd0);  wr(fa(4), 8'd9);
    wr(ra(11), 8'd0); wr(fa(11), 8'd9);
    wr(8'h08, 8'h10);
    repeat (20) @(negedge clk);
    chk("R5 low bank ch4", pwm_out, 16'h0010);
    wr(8'h08, 8'h00); wr(8'h0C, 8'h08);
    repeat (20) @(negedge clk);
    chk("R5 high bank ch11", pwm_out, 16'h0800);
    wr(8'h0C, 8'h00);
    repeat (3) @(negedge clk);
    chk("R5 all disabled", pwm_out, 0);

    // R6 direct writes
    wr(ra(6), 8'h21); rd(ra(6), d); chk("R6 rise ch6", d, 8'h21);
    wr(fa(13), 8'h07); rd(fa(13), d); chk("R6 fall ch13", d, 8'h07);
    wr(8'h00, 8'h03); rd(8'h00, d); chk("R6 prescale", d, 8'h03);

    // staged mode: reference ch0 rises at step 0, period 16 clocks
    wr(8'h00, 8'd0); wr(8'h04, 8'd15);
    wr(ra(0), 8'd0); wr(fa(0), 8'd1);
    wr(ra(1), 8'd2);
    wr(8'h08, 8'h01);
    wr(8'hE4, 8'h02);
    rd(8'hE4, d); chk("R7 mask readback", d, 8'h02);

    // R7 / R8 write one clock before the boundary
    wait_rise(0);
    repeat (13) @(negedge clk);
    wr(ra(1), 8'd5);
    rd(ra(1), d); chk("R7 pending stays hidden", d, 8'd2);
    rd(ra(1), d); chk("R8 early write applied", d, 8'd5);

    // R8 write on the boundary clock
    wait_rise(0);
    repeat (14) @(negedge clk);
    wr(ra(1), 8'd9);
    rd(ra(1), d); chk("R8 boundary write pending", d, 8'd5);
    repeat (16) @(negedge clk);
    rd(ra(1), d); chk("R8 boundary write next period", d, 8'd9);

    // R9 shared limit staged while a mask bit is set; R6 unmasked channel still direct
    wait_rise(0);
    wr(8'h04, 8'd7);
    rd(8'h04, d); chk("R9 limit held", d, 8'd15);
    wr(ra(2), 8'h33);
    rd(ra(2), d); chk("R6 unmasked ch2 direct", d, 8'h33);
    repeat (20) @(negedge clk);
    rd(8'h04, d); chk("R9 limit applied", d, 8'd7);

    // R1 reset mid-run
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1 outputs after re-reset", pwm_out, 0);
    rd(8'hE4, d); chk("R1 mask after re-reset", d, 0);
    rd(ra(1), d); chk("R1 rise ch1 after re-reset", d, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule